// File: doc/BRIEF.md
# Multi-Master Hardware Lock Bank

This block is a shared bank of lock words that several processors on one chip use to take turns at common peripherals. Each lock is a 32-bit register in a small address window. A plain load from a lock word works as an atomic test-and-set. It returns the lock's previous state and leaves the lock held, all in one access. A store of zero hands the lock back. A read-only summary word gives the held/free state of the lowest 32 locks in a single load.

Every processor has its own request port. Each port presents one access per cycle and gets a registered answer one cycle later. Ports that touch different locks proceed in parallel. When two or more ports target the same lock in the same cycle, the port with the lowest index wins. The others are held off with `req_ready` low and must present the access again, so exactly one contender can ever observe a lock as free.

Top module: `hwlock_bank`

## Requirements
- R1: The lock count `NUM_LOCKS` is one of 32, 64, 128 or 256. The summary word sits at byte offset 0x000 and lock n sits at byte offset 0x100 + 4*n. A lock read answers with a 32-bit word whose bits 31..1 are zero.
- R2: A granted read of a free lock returns 0 and leaves that lock held from the next cycle on.
- R3: A granted read of a held lock returns 1 and leaves the lock held.
- R4: A granted write of the value 0 to a lock releases it.
- R5: A read of offset 0x000 returns a word whose bit n is 1 exactly when lock n is held, for n from 0 to 31.
- R6: A write of any nonzero value to a lock, and any write to offset 0x000, changes no lock.
- R7: A read of any other offset returns 0 and changes no lock. This covers offsets between 0x004 and 0x0FC, offsets past the last lock, and offsets not a multiple of 4.
- R8: When several ports access the same lock in one cycle, only the lowest-numbered one is granted (`req_ready` high). The others see `req_ready` low and their access has no effect. Port 0 is never held off.
- R9: `req_ready` is combinational in the request cycle. Every granted access gets `resp_valid` high, with its data, in exactly the following cycle. With no granted access, `resp_valid` is low.
- R10: While `rst` is high and after it falls, every lock is free and the summary word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Access request, one bit per port |
| req_write | input | NUM_REQ | 1 = write, 0 = read, per port |
| req_addr | input | NUM_REQ*ADDR_W | Byte offset per port, port i at bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_REQ*32 | Write data per port |
| req_ready | output | NUM_REQ | Access granted this cycle |
| resp_valid | output | NUM_REQ | Response for the access granted in the previous cycle |
| resp_rdata | output | NUM_REQ*32 | Read data per port (0 for writes) |

## Verification
The bench sweeps every lock of a 32-lock, two-port bank through take, re-take, release and ignored nonzero store, and checks the summary word after each phase against a bit-vector model. Same-lock contention is the key corner. If arbitration were missing, both ports would read 0 and both would own the lock. If the loser's access were not suppressed, a release on the winning port would be followed by a stray take, or the loser would get a response. Address decode is checked at the edges of the window: the last legal lock, one word past it, the gap below 0x100, and unaligned offsets. A loose decode there would alias a lock and set it by accident. Stores to the summary word and nonzero stores to a lock are also checked, since a design that treated any store as a release would free a lock.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int WORD_W     = 32;
  localparam int LOCK_BASE  = 256;  // byte offset of lock 0
  localparam int STATUS_OFS = 0;    // byte offset of summary word
  localparam int STATUS_W   = 32;   // locks covered by the summary word
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_status,
  output logic              is_lock,
  output logic [IDX_W-1:0]  idx
);
  import hwlock_pkg::*;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_LOCKS * 4);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off       = addr - BASE_A;
    is_status = (addr == STAT_A);
    is_lock   = (addr >= BASE_A) && (off < SPAN_A) && (addr[1:0] == 2'b00);
    idx       = off[IDX_W+1:2];
  end
endmodule

// File: rtl/hwlock_arb.sv
module hwlock_arb #(
  parameter int NUM_REQ = 2,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_REQ-1:0]       valid,
  input  logic [NUM_REQ-1:0]       is_lock,
  input  logic [NUM_REQ*IDX_W-1:0] idx,
  output logic [NUM_REQ-1:0]       grant
);
  logic [NUM_REQ-1:0] blocked;

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NUM_REQ; j++) begin
        if (j < i && valid[j] && is_lock[j] && is_lock[i] &&
            idx[j*IDX_W +: IDX_W] == idx[i*IDX_W +: IDX_W])
          blocked[i] = 1'b1;
      end
      grant[i] = valid[i] && !blocked[i];
    end
  end

  // R8: the highest-priority port is never held off
  always_comb begin
    assert_port0_free_R8: assert (!valid[0] || grant[0]);
  end
endmodule

// File: rtl/hwlock_state.sv
module hwlock_state #(
  parameter int NUM_REQ   = 2,
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       take,
  input  logic [NUM_REQ-1:0]       drop,
  input  logic [NUM_REQ*IDX_W-1:0] idx,
  output logic [NUM_LOCKS-1:0]     lock_q
);
  logic [NUM_LOCKS-1:0] lock_d;

  always_comb begin
    lock_d = lock_q;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (take[i]) lock_d[idx[i*IDX_W +: IDX_W]] = 1'b1;
      if (drop[i]) lock_d[idx[i*IDX_W +: IDX_W]] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= lock_d;
  end

  // R6/R7: cycles without a take or release leave every lock alone
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (take == '0 && drop == '0) |=> $stable(lock_q));

  // R10: all locks free on leaving reset
  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lock_q == '0));
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank #(
  parameter int NUM_REQ   = 2,
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ-1:0]        req_write,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  input  logic [NUM_REQ*32-1:0]     req_wdata,
  output logic [NUM_REQ-1:0]        req_ready,
  output logic [NUM_REQ-1:0]        resp_valid,
  output logic [NUM_REQ*32-1:0]     resp_rdata
);
  import hwlock_pkg::*;
  localparam int IDX_W = $clog2(NUM_LOCKS);

  logic [NUM_REQ-1:0]        is_status, is_lock, grant, take, drop;
  logic [NUM_REQ*IDX_W-1:0]  idx;
  logic [NUM_LOCKS-1:0]      lock_q;
  logic [NUM_REQ*WORD_W-1:0] rd_word;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_port
    hwlock_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) dec_i (
      .addr      (req_addr[g*ADDR_W +: ADDR_W]),
      .is_status (is_status[g]),
      .is_lock   (is_lock[g]),
      .idx       (idx[g*IDX_W +: IDX_W])
    );
    assign take[g] = grant[g] && is_lock[g] && !req_write[g];
    assign drop[g] = grant[g] && is_lock[g] && req_write[g] &&
                     (req_wdata[g*WORD_W +: WORD_W] == '0);

    // R2: a granted lock read leaves that lock held
    assert_take_R2: assert property (@(posedge clk) disable iff (rst)
      take[g] |=> lock_q[$past(idx[g*IDX_W +: IDX_W])]);
    // R4: a granted zero store frees that lock
    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
      drop[g] |=> !lock_q[$past(idx[g*IDX_W +: IDX_W])]);
    // R1: a lock read answers with bits 31..1 clear
    assert_lockword_R1: assert property (@(posedge clk) disable iff (rst)
      $past(take[g]) |-> (resp_rdata[g*WORD_W+1 +: WORD_W-1] == '0));
  end

  hwlock_arb #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) arb_i (
    .valid   (req_valid),
    .is_lock (is_lock),
    .idx     (idx),
    .grant   (grant)
  );

  hwlock_state #(.NUM_REQ(NUM_REQ), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) st_i (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .drop   (drop),
    .idx    (idx),
    .lock_q (lock_q)
  );

  assign req_ready = grant;

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      rd_word[i*WORD_W +: WORD_W] = '0;
      if (!req_write[i]) begin
        if (is_status[i])
          rd_word[i*WORD_W +: WORD_W] = WORD_W'(lock_q[STATUS_W-1:0]);
        else if (is_lock[i])
          rd_word[i*WORD_W +: WORD_W] = WORD_W'(lock_q[idx[i*IDX_W +: IDX_W]]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= '0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= grant;
      for (int i = 0; i < NUM_REQ; i++)
        resp_rdata[i*WORD_W +: WORD_W] <= grant[i] ? rd_word[i*WORD_W +: WORD_W] : '0;
    end
  end
endmodule

// File: tb/hwlock_bank_tb.sv
`timescale 1ns/1ps
module hwlock_bank_tb_top;
  localparam int NR = 2, NL = 32, AW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [NR-1:0] req_valid = '0, req_write = '0, req_ready, resp_valid;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR*32-1:0] req_wdata = '0, resp_rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NL-1:0] model = '0;

  always #2.5 clk = ~clk;

  hwlock_bank #(.NUM_REQ(NR), .NUM_LOCKS(NL), .ADDR_W(AW)) dut_i (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] lk(int n);
    return AW'(256 + 4 * n);
  endfunction

  // one access on port p; returns response data
  task automatic acc(int p, bit wr, logic [AW-1:0] a, logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid[p] = 1'b1; req_write[p] = wr;
    req_addr[p*AW +: AW] = a; req_wdata[p*32 +: 32] = d;
    #1 check(req_ready[p] == 1'b1, "R9 ready", 32'(req_ready[p]), 1);
    @(negedge clk);
    check(resp_valid[p] == 1'b1, "R9 resp_valid", 32'(resp_valid[p]), 1);
    rd = resp_rdata[p*32 +: 32];
    req_valid = '0;
  endtask

  task automatic rd_lock(int p, int n, string req);
    logic [31:0] r;
    logic [31:0] e;
    e = 32'(model[n]);
    acc(p, 1'b0, lk(n), 0, r);
    check(r == e, req, r, e);
    model[n] = 1'b1;
  endtask

  task automatic wr_lock(int p, int n, logic [31:0] d);
    logic [31:0] r;
    acc(p, 1'b1, lk(n), d, r);
    if (d == 0) model[n] = 1'b0;
  endtask

  task automatic status(string req);
    logic [31:0] r;
    acc(0, 1'b0, '0, 0, r);
    check(r == model, req, r, model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [AW-1:0] bad [5];
    bad = '{12'h004, 12'h0FC, 12'h180, 12'h102, 12'hFFC};
    repeat (3) @(posedge clk);
    #1 check(resp_valid == '0, "R10 resp idle in reset", 32'(resp_valid), 0);
    @(negedge clk) rst = 1'b0;
    status("R10 status after reset");

    // sweep: take every lock, alternate ports
    for (int n = 0; n < NL; n++) rd_lock(n % 2, n, "R2 take free");
    @(negedge clk);
    check(resp_valid == '0, "R9 resp drops", 32'(resp_valid), 0);
    for (int n = 0; n < NL; n++) rd_lock((n + 1) % 2, n, "R3 retake held");
    status("R5 all held");
    for (int n = 0; n < NL; n += 2) wr_lock(n % 4 == 0 ? 0 : 1, n, 0);        // R4
    for (int n = 1; n < NL; n += 2) wr_lock(0, n, 32'(n) | 32'h10);           // R6 ignored
    status("R4/R6 even released, odd kept");
    rd_lock(1, 31, "R1 last lock held word");
    rd_lock(0, 30, "R1 lock 30 free then taken");
    wr_lock(0, 30, 0);
    acc(1, 1'b1, '0, 0, r);
    status("R6 status store ignored");
    acc(1, 1'b1, '0, 32'hFFFF_FFFF, r);
    status("R6 status store ones ignored");

    // unmapped offsets, with an odd lock freed so a bad alias would show
    wr_lock(0, 1, 0);
    foreach (bad[k]) begin
      acc(k % 2, 1'b0, bad[k], 0, r);
      check(r == 0, "R7 unmapped read zero", r, 0);
      acc(k % 2, 1'b1, bad[k], 0, r);
    end
    acc(0, 1'b0, 12'h105, 0, r);
    check(r == 0, "R7 unaligned read zero", r, 0);
    status("R7 unmapped left locks alone");

    // contention on lock 3: port 0 wins
    wr_lock(0, 3, 0);
    @(negedge clk);
    req_valid = 2'b11; req_write = 2'b00;
    req_addr = {lk(3), lk(3)};
    #1 check(req_ready == 2'b01, "R8 only port0 granted", 32'(req_ready), 1);
    @(negedge clk);
    check(resp_valid == 2'b01, "R8 loser no response", 32'(resp_valid), 1);
    check(resp_rdata[31:0] == 0, "R8 winner sees free", resp_rdata[31:0], 0);
    req_valid = '0; model[3] = 1'b1;
    rd_lock(1, 3, "R8 loser retry sees held");

    // different locks in parallel
    wr_lock(0, 4, 0); wr_lock(1, 6, 0);
    @(negedge clk);
    req_valid = 2'b11; req_write = 2'b00;
    req_addr = {lk(6), lk(4)};
    #1 check(req_ready == 2'b11, "R8 distinct locks both granted", 32'(req_ready), 3);
    @(negedge clk);
    check(resp_rdata == 64'd0, "R2 parallel takes free", resp_rdata[31:0], 0);
    req_valid = '0; model[4] = 1'b1; model[6] = 1'b1;

    // port 0 releases lock 5 while port 1 tries to take it: port 1 stalls
    @(negedge clk);
    req_valid = 2'b11; req_write = 2'b01;
    req_addr = {lk(5), lk(5)}; req_wdata = '0;
    #1 check(req_ready == 2'b01, "R8 release beats take", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = '0; model[5] = 1'b0;
    status("R8 stalled take had no effect");
    rd_lock(1, 5, "R2 take after release");
    status("R5 final summary");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule